// File: doc/BRIEF.md
# Carrier Phase Tracking Loop with Sample Derotator

This block removes a slowly varying carrier phase rotation from a stream of complex baseband samples. A phase detector elsewhere in the receiver measures the residual phase error once per averaging window (one symbol or one slot) and presents it on a strobed input. The block filters these measurements with a second-order loop (a proportional path plus an integrated frequency term) and keeps a phase estimate. It multiplies every sample that it accepts by the complex exponential of the current estimate.

The estimate addresses a single sine/cosine table with 1024 entries covering one full turn, so the angle resolution is π/512. Each 32-bit word of the table holds both the sine and the cosine. One lookup therefore feeds a full complex multiply on every clock. The multiply is pipelined over three register stages. The result is rounded and saturated back to the input width. A mode pin selects between the symbol-rate loop gains and the slot-rate loop gains.

Samples enter and leave through valid/ready handshakes. A transfer takes place on a rising clock edge where valid and ready are both high. The input is ready whenever the output register is empty or is being drained in the same cycle, so back-pressure at the output stalls the whole pipeline without losing or reordering samples. Once the output presents valid data it holds that data unchanged until it is taken. The phase-error strobe and the mode pin are plain control inputs and have no handshake.

Top module: `phase_derotator`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the phase estimate, the integrator and all pipeline valid flags. out_valid reads 0 during reset, and samples accepted after reset, before any error strobe, are rotated by zero phase (cosine word 32767, sine word 0).
- R2: On each edge with err_valid high, with e the signed 12-bit error in units of 2^-16 of a turn, the block computes a1 = floor(e·G1/256) and a2 = floor(e·G2/256). The phase is updated as phase ← phase + a1 + integ and the integrator as integ ← integ + a2, both modulo 2^16 and both using the values from before the edge. With mode_slot=0 (symbol rate) G1=77 and G2=26, which are 0.3 and 0.1 in steps of 1/256.
- R3: The phase and the integrator change only on edges with err_valid high. A sample accepted on the same edge as an error strobe, or earlier, uses the old phase. Only later samples see the new estimate.
- R4: The table index is phase bits [15:6]. Entry k is a 32-bit word with sine in bits [31:16] and cosine in bits [15:0]. Each half is round-half-away-from-zero of 32767·sin(k·π/512) or 32767·cos(k·π/512).
- R5: For an accepted sample (I,Q) and table values (c,s), the outputs are I' = (I·c − Q·s + 16384) >>> 15 and Q' = (I·s + Q·c + 16384) >>> 15, with arithmetic shifts. This is the input times exp(j·phase).
- R6: I' and Q' saturate to the signed 12-bit range [−2048, 2047].
- R7: in_ready = !out_valid || out_ready. Outputs come out in acceptance order with none dropped or duplicated. While out_valid is high and out_ready is low, out_valid, out_i and out_q hold steady. An accepted sample appears on the output after three advancing edges.
- R8: The phase accumulator wraps modulo one full turn (2^16). Continuous large errors drive it through several turns with no range check and no discontinuity in the rotation.
- R9: With mode_slot=1 (slot rate) the gains are G1=154 and G2=51, which are 0.6 and 0.2 in steps of 1/256. The pin is sampled only on edges with err_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept an input sample |
| in_i | input | 12 | Input sample, in-phase part, signed |
| in_q | input | 12 | Input sample, quadrature part, signed |
| err_valid | input | 1 | Strobe: a new phase-error measurement is present |
| err_phase | input | 12 | Phase error, signed, units of 2^-16 turn |
| mode_slot | input | 1 | 0: symbol-rate gains, 1: slot-rate gains |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream can take the output sample |
| out_i | output | 12 | Derotated in-phase part, signed |
| out_q | output | 12 | Derotated quadrature part, signed |

## Verification
The bench places error strobes in the same cycle as an accepted sample. A design that applies the new estimate one window early would fail those samples. It drives long runs of large errors so that the integrator winds the phase through several turns, which exposes accumulators that clamp, or table addressing taken from the wrong bits. Full-scale inputs near odd multiples of 45 degrees push the products past the 12-bit range, which catches a design that wraps instead of saturating or that rounds toward zero. Random back-pressure on out_ready shows whether a stalled pipeline drops, repeats or alters samples, or lets the gain select act outside an error strobe.

// File: rtl/phase_derot_pkg.sv
package phase_derot_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Scaled sine or cosine of a table position, rounded half away from zero.
  function automatic int scaled_trig(input int k, input int depth, input int amp, input bit want_sin);
    real ang;
    real v;
    ang = TWO_PI * real'(k) / real'(depth);
    v = want_sin ? $sin(ang) : $cos(ang);
    v = v * real'(amp);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else return -$rtoi(0.5 - v);
  endfunction

endpackage

// File: rtl/pdr_phase_loop.sv
module pdr_phase_loop #(
  parameter int PW  = 16,
  parameter int EW  = 12,
  parameter int GW  = 8,
  parameter int TW  = 10,
  parameter int G1S = 77,
  parameter int G2S = 26,
  parameter int G1L = 154,
  parameter int G2L = 51
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 err_valid,
  input  logic signed [EW-1:0] err,
  input  logic                 mode_slot,
  output logic [TW-1:0]        tbl_idx
);
  localparam int PRW = EW + GW + 1;

  logic [PW-1:0] phase_q, integ_q;
  logic [GW:0]   g1, g2;
  logic signed [PRW-1:0] prod1, prod2, sh1, sh2;
  logic [PW-1:0] step1, step2;

  always_comb begin
    g1 = mode_slot ? (GW+1)'(G1L) : (GW+1)'(G1S);
    g2 = mode_slot ? (GW+1)'(G2L) : (GW+1)'(G2S);
    prod1 = PRW'(err) * $signed(g1);
    prod2 = PRW'(err) * $signed(g2);
    sh1 = prod1 >>> GW;
    sh2 = prod2 >>> GW;
    step1 = PW'(sh1);
    step2 = PW'(sh2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      integ_q <= '0;
    end else if (err_valid) begin
      phase_q <= phase_q + step1 + integ_q;
      integ_q <= integ_q + step2;
    end
  end

  assign tbl_idx = phase_q[PW-1 -: TW];

  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !err_valid |=> $stable(phase_q)); // R3
  AST_INTEG_IDLE: assert property (@(posedge clk) disable iff (rst)
    !err_valid |=> $stable(integ_q)); // R2
  AST_ZERO_ERR_COAST: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err == '0) |=> phase_q == PW'($past(phase_q) + $past(integ_q))); // R8

endmodule

// File: rtl/pdr_sincos_rom.sv
module pdr_sincos_rom
  import phase_derot_pkg::*;
#(
  parameter int TW = 10,
  parameter int CW = 16
) (
  input  logic [TW-1:0]   addr,
  output logic [2*CW-1:0] word
);
  localparam int DEPTH = 1 << TW;
  localparam int AMP   = (1 << (CW-1)) - 1;

  logic [2*CW-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    localparam int SV = scaled_trig(k, DEPTH, AMP, 1'b1);
    localparam int CV = scaled_trig(k, DEPTH, AMP, 1'b0);
    assign tbl[k] = {CW'(SV), CW'(CV)};
  end

  assign word = tbl[addr];

endmodule

// File: rtl/pdr_cmul.sv
module pdr_cmul #(
  parameter int DW = 12,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [2*CW-1:0]      sc_word,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam int PDW = DW + CW;
  localparam int SW  = PDW + 1;
  localparam logic signed [SW-1:0] HALF  = SW'(1) <<< (CW-2);
  localparam logic signed [SW-1:0] S_MAX = SW'((1 << (DW-1)) - 1);
  localparam logic signed [SW-1:0] S_MIN = -SW'(1 << (DW-1));

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [SW-1:0] x);
    logic signed [SW-1:0] r;
    r = (x + HALF) >>> (CW-1);
    if (r > S_MAX) return DW'(S_MAX);
    else if (r < S_MIN) return DW'(S_MIN);
    else return DW'(r);
  endfunction

  logic adv;
  logic v1, v2, v3;
  logic signed [DW-1:0] i1, q1;
  logic signed [CW-1:0] s1, c1;
  logic signed [PDW-1:0] p_ic, p_qs, p_is, p_qc;

  assign adv      = !v3 || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      i1 <= in_i;
      q1 <= in_q;
      s1 <= $signed(sc_word[2*CW-1:CW]);
      c1 <= $signed(sc_word[CW-1:0]);
      p_ic <= PDW'(i1) * PDW'(c1);
      p_qs <= PDW'(q1) * PDW'(s1);
      p_is <= PDW'(i1) * PDW'(s1);
      p_qc <= PDW'(q1) * PDW'(c1);
      out_i <= rnd_sat(SW'(p_ic) - SW'(p_qs));
      out_q <= rnd_sat(SW'(p_is) + SW'(p_qc));
    end
  end

  assign out_valid = v3;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q))); // R7
  AST_NO_GAIN_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    (v2 && !adv) |=> v2); // R7

endmodule

// File: rtl/phase_derotator.sv
module phase_derotator #(
  parameter int DW  = 12,
  parameter int EW  = 12,
  parameter int PW  = 16,
  parameter int TW  = 10,
  parameter int CW  = 16,
  parameter int GW  = 8,
  parameter int G1S = 77,
  parameter int G2S = 26,
  parameter int G1L = 154,
  parameter int G2L = 51
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic                 err_valid,
  input  logic signed [EW-1:0] err_phase,
  input  logic                 mode_slot,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  logic [TW-1:0]   idx;
  logic [2*CW-1:0] word;

  pdr_phase_loop #(.PW(PW), .EW(EW), .GW(GW), .TW(TW),
                   .G1S(G1S), .G2S(G2S), .G1L(G1L), .G2L(G2L)) u_loop (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err(err_phase),
    .mode_slot(mode_slot), .tbl_idx(idx));

  pdr_sincos_rom #(.TW(TW), .CW(CW)) u_rom (.addr(idx), .word(word));

  pdr_cmul #(.DW(DW), .CW(CW)) u_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .sc_word(word),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q));

  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> !out_valid); // R1

endmodule

// File: tb/tb_phase_derotator.sv
module tb_phase_derotator;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, err_valid = 1'b0, mode_slot = 1'b0, out_ready = 1'b0;
  logic signed [11:0] in_i = '0, in_q = '0, err_phase = '0;
  logic in_ready, out_valid;
  logic signed [11:0] out_i, out_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_derotator dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .err_valid(err_valid), .err_phase(err_phase),
    .mode_slot(mode_slot), .out_valid(out_valid), .out_ready(out_ready),
    .out_i(out_i), .out_q(out_q));

  int checks = 0, errors = 0;
  int m_phase = 0, m_integ = 0;
  int exp_i[$], exp_q[$];
  string exp_tag[$];
  int n_in = 0, n_out = 0;
  bit held = 0;
  int held_i = 0, held_q = 0;

  function automatic int rnd_half(input real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

  function automatic int tsin(input int k);
    return rnd_half(32767.0 * $sin(3.141592653589793 * real'(k) / 512.0));
  endfunction

  function automatic int tcos(input int k);
    return rnd_half(32767.0 * $cos(3.141592653589793 * real'(k) / 512.0));
  endfunction

  function automatic int sat12(input int x);
    if (x > 2047) return 2047;
    if (x < -2048) return -2048;
    return x;
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // One clock: drive at negedge, observe after settling, update the reference model.
  task automatic step(input bit v, input int si, input int sq, input bit ev, input int e,
                      input bit md, input bit ordy, input string tag);
    int k, c, s, g1, g2;
    @(negedge clk);
    in_valid = v; in_i = 12'(si); in_q = 12'(sq);
    err_valid = ev; err_phase = 12'(e); mode_slot = md; out_ready = ordy;
    #1;
    if (held) begin
      check("R7 stall hold", out_valid && int'(out_i) == held_i && int'(out_q) == held_q,
            int'(out_i), held_i);
    end
    held = out_valid && !out_ready;
    held_i = int'(out_i); held_q = int'(out_q);
    if (out_valid && out_ready) begin
      n_out++;
      if (exp_i.size() == 0) check("R7 extra output", 1'b0, n_out, n_in);
      else begin
        string t;
        int ei, eq;
        ei = exp_i.pop_front(); eq = exp_q.pop_front(); t = exp_tag.pop_front();
        check({t, " I"}, int'(out_i) == ei, int'(out_i), ei);
        check({t, " Q"}, int'(out_q) == eq, int'(out_q), eq);
      end
    end
    check("R7 ready rule", in_ready == (!out_valid || out_ready), int'(in_ready),
          int'(!out_valid || out_ready));
    if (v && in_ready) begin
      n_in++;
      k = m_phase >> 6;
      c = tcos(k); s = tsin(k);
      exp_i.push_back(sat12((si * c - sq * s + 16384) >>> 15));
      exp_q.push_back(sat12((si * s + sq * c + 16384) >>> 15));
      exp_tag.push_back(tag);
    end
    if (ev) begin
      g1 = md ? 154 : 77;
      g2 = md ? 51 : 26;
      m_phase = (m_phase + ((e * g1) >>> 8) + m_integ) & 16'hFFFF;
      m_integ = (m_integ + ((e * g2) >>> 8)) & 16'hFFFF;
    end
  endtask

  function automatic int rs12();
    return int'($signed(12'($urandom)));
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset out_valid", out_valid == 1'b0, int'(out_valid), 0);
    @(negedge clk); rst = 1'b0;

    // R1: zero phase after reset
    step(1, 2047, 0, 0, 0, 0, 1, "R1");
    step(1, -2048, 1000, 0, 0, 0, 1, "R1");
    step(1, 123, -456, 0, 0, 0, 1, "R1");
    for (int n = 0; n < 4; n++) step(0, 0, 0, 0, 0, 0, 1, "R1");

    // R3: strobe in the same cycle as a sample, then a sample after it
    step(1, 1500, -700, 1, 1800, 0, 1, "R3");
    step(1, 1500, -700, 0, 0, 0, 1, "R3");
    step(1, -900, 300, 1, -2000, 0, 1, "R3");
    step(1, -900, 300, 0, 0, 0, 1, "R3");

    // R2: symbol-rate gains, random samples and errors
    for (int n = 0; n < 400; n++)
      step(1, rs12(), rs12(), ($urandom % 8) == 0, rs12(), 0, 1, "R2");

    // R9: slot-rate gains, pin toggled outside strobes too
    for (int n = 0; n < 400; n++) begin
      bit ev;
      ev = ($urandom % 6) == 0;
      step(1, rs12(), rs12(), ev, rs12(), ev ? 1'b1 : 1'($urandom), 1, "R9");
    end

    // R7: random back-pressure and input gaps
    for (int n = 0; n < 600; n++)
      step(1'($urandom), rs12(), rs12(), ($urandom % 10) == 0, rs12(), 1'($urandom),
           ($urandom % 3) != 0, "R7");

    // R6: full-scale corners at every phase the loop visits
    for (int n = 0; n < 400; n++) begin
      int a, b;
      a = ($urandom % 2) ? 2047 : -2048;
      b = ($urandom % 2) ? 2047 : -2048;
      step(1, a, b, ($urandom % 4) == 0, 700, 0, 1, "R6");
    end

    // R8: long run of maximum error winds the phase through many turns
    for (int n = 0; n < 500; n++)
      step(1, rs12(), rs12(), 1, 2047, 1, 1, "R8");
    for (int n = 0; n < 300; n++)
      step(1, rs12(), rs12(), 1, -2048, 0, 1, "R8");

    // R4/R5: general random mix
    for (int n = 0; n < 400; n++)
      step(1, rs12(), rs12(), ($urandom % 5) == 0, rs12(), 1'($urandom), 1, "R4/R5");

    for (int n = 0; n < 10; n++) step(0, 0, 0, 0, 0, 0, 1, "R7");
    check("R7 all delivered", exp_i.size() == 0 && n_in == n_out, n_out, n_in);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule